// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker and Inserter

This block sits in a 10-bit parallel video word stream and follows ancillary data packets. The source marks the first word of each packet, which is the first of the three flag words, with a start strobe. From the start strobe the block counts words. It reads the user-data length from the data count word and keeps a 9-bit running sum over the words that the checksum covers. The three flag words are not part of that sum.

Two control bits set how each packet is handled. The block samples both bits on the start word. In one mode the packet brings its own checksum word. The block compares that word with the value it computed. On a mismatch it either leaves the word as it is and raises a sticky error, or it writes the correct value in place of the bad one. In the other mode the packet has no checksum word. The block builds the checksum and places it in the stream right after the last user word. Every other word goes through with exactly one clock of delay.

Top module: `anc_csum_unit`

## Requirements
- R1: A valid input word that is not a received checksum word appears on `out_word` with `out_vld` high exactly one clock after it is sampled, and its value is unchanged.
- R2: The computed checksum is the modulo-512 sum of bits [8:0] of the data ID, second ID, data count and every user data word. Bit 9 of the checksum is the inverse of bit 8. The three flag words (the start word and the two words after it) are not counted.
- R3: The data count is the sixth word, where the start word is word 0. Its bits [7:0] give the number of user data words (0 to 255) that follow it.
- R4: When `cfg_attach`=1 and `cfg_force`=0, a received checksum word that differs from the computed value leaves the block unchanged, and `sum_err` goes high in the same cycle that this word appears on the output.
- R5: When `cfg_attach`=1 and `cfg_force`=1, a received checksum word that differs from the computed value is replaced on the output by the computed value, and `sum_err` does not change.
- R6: When `cfg_attach`=1 and the received checksum matches the computed value, the checksum word passes unchanged and `sum_err` stays low.
- R7: When `cfg_attach`=0, the computed checksum appears on the output in the cycle right after the last user word is output. If the data count is 0, it appears right after the data count word.
- R8: A valid input word sampled in the cycle in which a checksum is being appended is discarded and never appears on the output.
- R9: Once set, `sum_err` stays high until `err_rd` is pulsed or reset is applied. If a new error and `err_rd` occur in the same cycle, the flag stays set.
- R10: `cfg_attach` and `cfg_force` are sampled only with the start word. A change to either bit during a packet has no effect on how that packet is handled.
- R11: If `in_eop` arrives before the position given by the data count, the packet is closed. No checksum is checked or appended for it, and the words that follow are passed through as loose words.
- R12: A start word that arrives in the middle of a packet drops the old packet and begins a new one with a cleared sum.
- R13: While reset is asserted, and on the clock after it is asserted, `out_vld` and `sum_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 10 | Input stream word |
| in_vld | input | 1 | Input word valid |
| in_sop | input | 1 | Marks the first flag word of a packet |
| in_eop | input | 1 | Marks the last word the source sends for a packet |
| cfg_attach | input | 1 | 1: packets carry a checksum to be checked; 0: the block appends one |
| cfg_force | input | 1 | 1: a received checksum that mismatches is overwritten |
| err_rd | input | 1 | Read strobe that clears the sticky error |
| out_word | output | 10 | Output stream word, one clock behind the input |
| out_vld | output | 1 | Output word valid |
| sum_err | output | 1 | Sticky checksum mismatch flag |

## Verification
A wrong count in the word-position tracker moves the compare or the append to the wrong word. This shows up at the packet's checksum slot, either as an extra output word in append mode or as a false or missing `sum_err` in check mode. A corrupted running sum gives a wrong appended or replaced value one clock after the checksum slot is sampled. A stuck pending-append state either drops or duplicates words in the next output cycle. The scoreboard compares every output word in order, so any of these faults is reported within the packet in which it happens.

// File: rtl/anc_csum_pkg.sv
`timescale 1ns/1ps
package anc_csum_pkg;
  // Position of the tracker inside an ancillary packet.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_FLAG = 3'd1,
    PH_HDR  = 3'd2,
    PH_UDW  = 3'd3,
    PH_SUM  = 3'd4
  } anc_phase_t;

  localparam int FLAG_WORDS = 3;
  localparam int HDR_WORDS  = 3;
endpackage

// File: rtl/anc_pkt_tracker.sv
`timescale 1ns/1ps
module anc_pkt_tracker
  import anc_csum_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             sop,
  input  logic             eop,
  input  logic [CNT_W-1:0] dc_field,
  input  logic             att_in,
  input  logic             frc_in,
  output logic             sum_clr,
  output logic             add_en,
  output logic             sum_slot,
  output logic             app_req,
  output logic             att_lat,
  output logic             frc_lat
);
  localparam int IDX_W = 2;
  localparam logic [IDX_W-1:0] FLAG_LAST = IDX_W'(FLAG_WORDS - 1);
  localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(HDR_WORDS - 1);

  anc_phase_t       phase;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] left;
  logic             mid;
  logic             last_data;

  assign mid       = vld && !sop;
  assign sum_clr   = vld && sop;
  assign add_en    = mid && (phase == PH_HDR || phase == PH_UDW);
  assign sum_slot  = mid && (phase == PH_SUM);
  assign last_data = mid && ((phase == PH_HDR && idx == HDR_LAST && dc_field == '0) ||
                             (phase == PH_UDW && left == CNT_W'(1)));
  assign app_req   = last_data && !att_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      idx     <= '0;
      left    <= '0;
      att_lat <= 1'b0;
      frc_lat <= 1'b0;
    end else if (vld) begin
      if (sop) begin
        phase   <= PH_FLAG;
        idx     <= IDX_W'(1);
        att_lat <= att_in;
        frc_lat <= frc_in;
      end else begin
        unique case (phase)
          PH_FLAG: begin
            if (idx == FLAG_LAST) begin
              phase <= PH_HDR;
              idx   <= '0;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
          PH_HDR: begin
            if (idx == HDR_LAST) begin
              left <= dc_field;
              if (dc_field == '0) phase <= att_lat ? PH_SUM : PH_IDLE;
              else                phase <= PH_UDW;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
          PH_UDW: begin
            left <= left - CNT_W'(1);
            if (left == CNT_W'(1)) phase <= att_lat ? PH_SUM : PH_IDLE;
          end
          PH_SUM:  phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
      end
      if (eop) phase <= PH_IDLE;
    end
  end
endmodule

// File: rtl/anc_sum_acc.sv
`timescale 1ns/1ps
module anc_sum_acc #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add_en,
  input  logic [WORD_W-2:0] sum_bits,
  output logic [WORD_W-1:0] calc_word
);
  localparam int SUM_W = WORD_W - 1;

  logic [SUM_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (add_en) acc <= acc + sum_bits;
  end

  assign calc_word = {~acc[SUM_W-1], acc};
endmodule

// File: rtl/anc_out_stage.sv
`timescale 1ns/1ps
module anc_out_stage #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_vld,
  input  logic              sum_slot,
  input  logic              app_req,
  input  logic              frc_lat,
  input  logic [WORD_W-1:0] calc_word,
  input  logic              err_rd,
  output logic [WORD_W-1:0] out_word,
  output logic              out_vld,
  output logic              sum_err,
  output logic              app_pend
);
  logic mismatch;
  logic do_fix;
  logic do_flag;

  assign mismatch = in_word != calc_word;
  assign do_fix   = sum_slot && frc_lat && mismatch;
  assign do_flag  = sum_slot && !frc_lat && mismatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word <= '0;
      out_vld  <= 1'b0;
      sum_err  <= 1'b0;
      app_pend <= 1'b0;
    end else begin
      app_pend <= app_req;
      if (app_pend) begin
        out_vld  <= 1'b1;
        out_word <= calc_word;
      end else begin
        out_vld  <= in_vld;
        out_word <= do_fix ? calc_word : in_word;
      end
      sum_err <= (sum_err && !err_rd) || do_flag;
    end
  end
endmodule

// File: rtl/anc_csum_unit.sv
`timescale 1ns/1ps
module anc_csum_unit #(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_vld,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              cfg_attach,
  input  logic              cfg_force,
  input  logic              err_rd,
  output logic [WORD_W-1:0] out_word,
  output logic              out_vld,
  output logic              sum_err
);
  localparam int SUM_W = WORD_W - 1;

  logic              vld_g;
  logic              sum_clr;
  logic              add_en;
  logic              sum_slot;
  logic              app_req;
  logic              app_pend;
  logic              att_lat;
  logic              frc_lat;
  logic [WORD_W-1:0] calc_word;

  // The cycle used by an appended checksum takes the input word's place.
  assign vld_g = in_vld && !app_pend;

  anc_pkt_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .vld      (vld_g),
    .sop      (in_sop),
    .eop      (in_eop),
    .dc_field (in_word[CNT_W-1:0]),
    .att_in   (cfg_attach),
    .frc_in   (cfg_force),
    .sum_clr  (sum_clr),
    .add_en   (add_en),
    .sum_slot (sum_slot),
    .app_req  (app_req),
    .att_lat  (att_lat),
    .frc_lat  (frc_lat)
  );

  anc_sum_acc #(.WORD_W(WORD_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clr       (sum_clr),
    .add_en    (add_en),
    .sum_bits  (in_word[SUM_W-1:0]),
    .calc_word (calc_word)
  );

  anc_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_word   (in_word),
    .in_vld    (vld_g),
    .sum_slot  (sum_slot && att_lat),
    .app_req   (app_req),
    .frc_lat   (frc_lat),
    .calc_word (calc_word),
    .err_rd    (err_rd),
    .out_word  (out_word),
    .out_vld   (out_vld),
    .sum_err   (sum_err),
    .app_pend  (app_pend)
  );
endmodule

// File: rtl/anc_csum_chk.sv
`timescale 1ns/1ps
module anc_csum_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] in_word,
  input logic              in_vld,
  input logic [WORD_W-1:0] out_word,
  input logic              out_vld,
  input logic              sum_err,
  input logic              err_rd,
  input logic              app_pend,
  input logic              sum_slot,
  input logic              frc_lat,
  input logic [WORD_W-1:0] calc_word
);
  p_rst_quiet_r13: assert property (@(posedge clk)
    rst |=> (!out_vld && !sum_err));

  p_pass_lat_r1: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !app_pend && !sum_slot) |=> (out_vld && out_word == $past(in_word)));

  p_append_r7: assert property (@(posedge clk) disable iff (rst)
    app_pend |=> (out_vld && out_word == $past(calc_word)));

  p_sum_inv_r2: assert property (@(posedge clk) disable iff (rst)
    app_pend |=> (out_word[WORD_W-1] != out_word[WORD_W-2]));

  p_replace_r5: assert property (@(posedge clk) disable iff (rst)
    (sum_slot && frc_lat) |=> (out_word == $past(calc_word)));

  p_no_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (sum_slot && frc_lat && !err_rd) |=> (sum_err == $past(sum_err)));

  p_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (sum_slot && !frc_lat && in_word != calc_word) |=> sum_err);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (sum_err && !err_rd) |=> sum_err);
endmodule

bind anc_csum_unit anc_csum_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_word   (in_word),
  .in_vld    (in_vld),
  .out_word  (out_word),
  .out_vld   (out_vld),
  .sum_err   (sum_err),
  .err_rd    (err_rd),
  .app_pend  (app_pend),
  .sum_slot  (sum_slot && att_lat),
  .frc_lat   (frc_lat),
  .calc_word (calc_word)
);

// File: tb/anc_csum_unit_bench.sv
`timescale 1ns/1ps
module anc_csum_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] in_word = '0;
  logic       in_vld = 1'b0;
  logic       in_sop = 1'b0;
  logic       in_eop = 1'b0;
  logic       cfg_attach = 1'b0;
  logic       cfg_force = 1'b0;
  logic       err_rd = 1'b0;
  logic [9:0] out_word;
  logic       out_vld;
  logic       sum_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  anc_csum_unit u_anc_csum_unit (
    .clk(clk), .rst(rst), .in_word(in_word), .in_vld(in_vld),
    .in_sop(in_sop), .in_eop(in_eop), .cfg_attach(cfg_attach),
    .cfg_force(cfg_force), .err_rd(err_rd), .out_word(out_word),
    .out_vld(out_vld), .sum_err(sum_err)
  );

  // Monitor: pops the scoreboard for every output word.
  always @(negedge clk) begin
    if (!rst && out_vld && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 R8 R11 unexpected output word: actual %h expected none", out_word);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_word !== e) begin
          errors++;
          $display("FAIL %s output word: actual %h expected %h", t, out_word, e);
        end
      end
    end
  end

  task automatic drv(input logic [9:0] w, input bit s, input bit e, input bit push,
                     input bit clr, input string tag);
    @(negedge clk);
    in_word = w; in_vld = 1'b1; in_sop = s; in_eop = e; err_rd = clr;
    if (push) begin exp_q.push_back(w); tag_q.push_back(tag); end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0; err_rd = 1'b0;
    end
  endtask

  task automatic chk_err(input bit exp, input string tag);
    checks++;
    if (sum_err !== exp) begin
      errors++;
      $display("FAIL %s sum_err: actual %b expected %b", tag, sum_err, exp);
    end
  endtask

  task automatic clear_err();
    @(negedge clk);
    in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0; err_rd = 1'b1;
    @(negedge clk);
    err_rd = 1'b0;
    chk_err(1'b0, "R9 clear by read strobe");
  endtask

  // Sends one packet; ends after the slot cycle that follows it.
  task automatic send_pkt(input bit att, input bit frc, input int n, input int seed,
                          input bit bad, input bit flip, input bit slot_busy,
                          input bit clr_at_sum, input string tag);
    logic [9:0] w;
    logic [8:0] s;
    logic [9:0] cs;
    logic [9:0] rx;
    s = '0;
    @(negedge clk);
    cfg_attach = att; cfg_force = frc;
    in_word = 10'h000; in_vld = 1'b1; in_sop = 1'b1; in_eop = 1'b0; err_rd = 1'b0;
    exp_q.push_back(10'h000); tag_q.push_back(tag);
    drv(10'h3FF, 0, 0, 1, 0, tag);
    if (flip) begin cfg_attach = ~att; cfg_force = ~frc; end
    drv(10'h3FF, 0, 0, 1, 0, tag);
    w = 10'((seed * 13 + 7) & 10'h3FF); s = s + w[8:0]; drv(w, 0, 0, 1, 0, tag);
    w = 10'((seed * 29 + 3) & 10'h3FF); s = s + w[8:0]; drv(w, 0, 0, 1, 0, tag);
    w = {2'b01, 8'(n)}; s = s + w[8:0];
    drv(w, 0, (n == 0) && !att, 1, 0, tag);
    for (int i = 0; i < n; i++) begin
      w = 10'((seed * 7 + i * 37 + 11) & 10'h3FF);
      s = s + w[8:0];
      drv(w, 0, (i == n - 1) && !att, 1, 0, tag);
    end
    cs = {~s[8], s};
    if (att) begin
      rx = bad ? (cs ^ 10'h021) : cs;
      drv(rx, 0, 1, 0, clr_at_sum, tag);
      exp_q.push_back((bad && frc) ? cs : rx); tag_q.push_back(tag);
      idle(1);
    end else begin
      exp_q.push_back(cs); tag_q.push_back(tag);
      if (slot_busy) drv(10'h155, 0, 0, 0, 0, "R8");
      else idle(1);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || sum_err !== 1'b0) begin
      errors++;
      $display("FAIL R13 reset outputs: actual vld %b err %b expected 0 0", out_vld, sum_err);
    end
    rst = 1'b0;
    idle(2);

    // R1: loose words outside any packet
    for (int i = 0; i < 6; i++) drv(10'(i * 91 + 5), 0, 0, 1, 0, "R1 loose word");
    idle(2);

    // R6: matching received checksum
    send_pkt(1, 0, 4, 3, 0, 0, 0, 0, "R6 matching checksum");
    chk_err(1'b0, "R6 no error on match");

    // R2 R7 R3: appended checksums with several lengths
    send_pkt(0, 0, 5, 9, 0, 0, 0, 0, "R2 R7 append n=5");
    send_pkt(0, 1, 0, 21, 0, 0, 0, 0, "R3 R7 append n=0");
    send_pkt(0, 0, 255, 4, 0, 0, 0, 0, "R3 append n=255");
    send_pkt(0, 0, 1, 17, 0, 0, 0, 0, "R2 append n=1");

    // R5: force overwrites a bad checksum
    send_pkt(1, 1, 3, 12, 1, 0, 0, 0, "R5 replace bad checksum");
    chk_err(1'b0, "R5 no error when forcing");

    // R4 R9: report only, sticky
    send_pkt(1, 0, 6, 40, 1, 0, 0, 0, "R4 report bad checksum");
    chk_err(1'b1, "R4 error set");
    idle(4);
    chk_err(1'b1, "R9 error held");
    send_pkt(1, 0, 2, 41, 0, 0, 0, 0, "R9 good packet keeps flag");
    chk_err(1'b1, "R9 error held after good packet");
    clear_err();

    // R9: new error and read strobe in the same cycle
    send_pkt(1, 0, 2, 50, 1, 0, 0, 0, "R4 set before collision");
    send_pkt(1, 0, 2, 51, 1, 0, 0, 1, "R9 set wins over clear");
    chk_err(1'b1, "R9 set wins over clear");
    clear_err();

    // R8: word in the append slot is dropped
    send_pkt(0, 0, 3, 60, 0, 0, 1, 0, "R8 append with busy slot");
    idle(2);

    // R10: mode bits flipped mid packet
    send_pkt(1, 0, 4, 70, 1, 1, 0, 0, "R10 latched report mode");
    chk_err(1'b1, "R10 latched mode still reports");
    clear_err();

    // R11: early end, append mode (no checksum must appear)
    cfg_attach = 1'b0;
    drv(10'h000, 1, 0, 1, 0, "R11 abort");
    drv(10'h3FF, 0, 0, 1, 0, "R11 abort");
    drv(10'h3FF, 0, 0, 1, 0, "R11 abort");
    drv(10'h041, 0, 0, 1, 0, "R11 abort");
    drv(10'h102, 0, 0, 1, 0, "R11 abort");
    drv(10'h104, 0, 0, 1, 0, "R11 abort");
    drv(10'h0AA, 0, 1, 1, 0, "R11 abort");
    idle(3);
    // R11: early end, check mode, then a stray word is not compared
    cfg_attach = 1'b1;
    drv(10'h000, 1, 0, 1, 0, "R11 abort check");
    drv(10'h3FF, 0, 0, 1, 0, "R11 abort check");
    drv(10'h3FF, 0, 0, 1, 0, "R11 abort check");
    drv(10'h041, 0, 0, 1, 0, "R11 abort check");
    drv(10'h102, 0, 1, 1, 0, "R11 abort check");
    drv(10'h123, 0, 0, 1, 0, "R11 stray word");
    drv(10'h2AB, 0, 0, 1, 0, "R11 stray word");
    idle(2);
    chk_err(1'b0, "R11 no check after early end");

    // R12: restart in the middle of a packet
    cfg_attach = 1'b0;
    drv(10'h000, 1, 0, 1, 0, "R12 old packet");
    drv(10'h3FF, 0, 0, 1, 0, "R12 old packet");
    drv(10'h3FF, 0, 0, 1, 0, "R12 old packet");
    drv(10'h1F0, 0, 0, 1, 0, "R12 old packet");
    drv(10'h0E1, 0, 0, 1, 0, "R12 old packet");
    drv(10'h103, 0, 0, 1, 0, "R12 old packet");
    drv(10'h077, 0, 0, 1, 0, "R12 old packet");
    send_pkt(0, 0, 4, 88, 0, 0, 0, 0, "R12 restarted packet");
    idle(2);

    // R13 R9: reset clears a set flag
    send_pkt(1, 0, 1, 95, 1, 0, 0, 0, "R4 set before reset");
    chk_err(1'b1, "R4 error set before reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk_err(1'b0, "R13 reset clears error");
    checks++;
    if (out_vld !== 1'b0) begin
      errors++;
      $display("FAIL R13 out_vld in reset: actual %b expected 0", out_vld);
    end
    rst = 1'b0;
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 R1 missing output words: actual %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    summary();
  end
endmodule